// File: doc/BRIEF.md
# Selectable-Precision Output Rounder

This block is the last stage of a two-source pixel mixer. It receives the doubled weighted sum at output-LSB weight, with one bit of headroom above the 13-bit output range. Each pixel arrives with a 2-bit precision code and a format bit. The block rounds the value to the requested number of significant bits and clears the bits below the kept field. When the result leaves the range of the pixel's own format, it clamps the result to the nearest limit and raises an overflow flag. The result is registered and presented on a 13-bit bus behind an active-low drive control.

The precision code and the format bit travel down the pipeline with their pixel. A change of either therefore affects only the pixel that was sampled with it. Pixels already inside the block are not affected. When the valid input is low, the pipeline holds its last result.

Top module: `mix_out_rounder`

## Requirements
- R1: The precision code sets how many of the 13 bits are kept. Code 0 keeps the top 8 bits, code 1 keeps 10, code 2 keeps 12 and code 3 keeps all 13. Every bit below the kept field reads zero on every result, saturated or not.
- R2: Rounding adds one at the bit just below the kept LSB before the low bits are cleared, so a value exactly halfway rounds up. In signed mode this is toward positive.
- R3: The precision code and the format bit are sampled together with their pixel. A change of either on one cycle alters only that pixel's result, and neighbouring pixels in flight keep their own settings.
- R4: With signed_i = 0, sum_i is unsigned. A rounded result above 0x1FFF gives ovf_o = 1 and the word 0x1FFF with the low bits cleared for the selected precision.
- R5: With signed_i = 1, sum_i is 14-bit two's complement. A rounded result above 4095 gives 0x0FFF with the low bits cleared. A result below -4096 gives 0x1000. Both raise ovf_o.
- R6: ovf_o is 0 for every pixel whose rounded result lies inside its format's range.
- R7: A pixel sampled with valid_i = 1 at a clock edge appears on data_o, ovf_o and valid_o after the second following edge. valid_o repeats valid_i two cycles later.
- R8: When valid_i is low, sum_i, prec_i and signed_i are ignored. data_o and ovf_o keep the last valid result.
- R9: While oe_ni is 1, data_o reads zero and drive_o is 0, with no clock edge needed. Returning oe_ni to 0 shows the held result again at once.
- R10: During and after asynchronous reset, valid_o, data_o and ovf_o are zero until the first valid result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel on sum_i is valid |
| sum_i | input | OUT_W+HEAD_W (14) | Doubled mixed sum at output-LSB weight |
| prec_i | input | 2 | Precision code (0: 8, 1: 10, 2: 12, 3: 13 bits) |
| signed_i | input | 1 | 1: two's complement, 0: unsigned |
| oe_ni | input | 1 | Output drive control, active low |
| valid_o | output | 1 | Result on data_o is newly valid |
| data_o | output | OUT_W (13) | Rounded, saturated result |
| ovf_o | output | 1 | Result was clamped to a limit |
| drive_o | output | 1 | Bus is being driven |

## Verification
The rounding increment and the saturation can hit the same pixel. This happens when a value inside the range is pushed past the limit by the half-LSB carry. Examples are unsigned 0x1FF0 at 8 bits and signed 0x0FFF at 12 bits. These pixels are driven directly. Each result is judged against an integer model that first rounds, then compares with the format limit, then masks, and it must show both the flag and the masked limit. Precision and format are also switched on consecutive cycles with invalid gaps, so the per-pixel carrying of the controls is judged in the same run.

// File: rtl/mix_round_pkg.sv
package mix_round_pkg;

  typedef enum logic [1:0] {
    PREC_COARSE = 2'd0,
    PREC_MED    = 2'd1,
    PREC_FINE   = 2'd2,
    PREC_FULL   = 2'd3
  } prec_e;

  localparam int PREC_N = 4;

endpackage

// File: rtl/mix_round_mask.sv
module mix_round_mask
  import mix_round_pkg::*;
#(
  parameter int OUT_W = 13,
  parameter int K0    = 8,
  parameter int K1    = 10,
  parameter int K2    = 12
) (
  input  prec_e              prec_i,
  output logic [OUT_W-1:0]   bias_o,
  output logic [OUT_W-1:0]   mask_o
);

  logic [OUT_W-1:0] bias_tab [PREC_N];
  logic [OUT_W-1:0] mask_tab [PREC_N];

  for (genvar c = 0; c < PREC_N; c++) begin : g_code
    localparam int KEEP = (c == 0) ? K0 : (c == 1) ? K1 : (c == 2) ? K2 : OUT_W;
    localparam int DROP = OUT_W - KEEP;
    assign mask_tab[c] = ~(OUT_W'((2 ** DROP) - 1));
    if (DROP == 0) begin : g_exact
      assign bias_tab[c] = '0;
    end else begin : g_half
      assign bias_tab[c] = OUT_W'(2 ** (DROP - 1));
    end
  end

  assign bias_o = bias_tab[prec_i];
  assign mask_o = mask_tab[prec_i];

endmodule

// File: rtl/mix_round_add.sv
module mix_round_add #(
  parameter int OUT_W  = 13,
  parameter int HEAD_W = 1,
  localparam int SUM_W = OUT_W + HEAD_W,
  localparam int RW    = SUM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SUM_W-1:0]  sum_i,
  input  logic              sgn_i,
  input  logic [OUT_W-1:0]  bias_i,
  input  logic [OUT_W-1:0]  mask_i,
  output logic              vld_o,
  output logic              sgn_o,
  output logic [RW-1:0]     rnd_o,
  output logic [OUT_W-1:0]  mask_o
);

  logic [RW-1:0] ext;
  logic [RW-1:0] rnd_d;

  // one spare top bit keeps the carry of the increment
  assign ext   = sgn_i ? {sum_i[SUM_W-1], sum_i} : {1'b0, sum_i};
  assign rnd_d = ext + {{(RW-OUT_W){1'b0}}, bias_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      sgn_o  <= 1'b0;
      rnd_o  <= '0;
      mask_o <= '1;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        sgn_o  <= sgn_i;
        rnd_o  <= rnd_d;
        mask_o <= mask_i;
      end
    end
  end

endmodule

// File: rtl/mix_round_sat.sv
module mix_round_sat #(
  parameter int OUT_W  = 13,
  parameter int HEAD_W = 1,
  localparam int RW    = OUT_W + HEAD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              sgn_i,
  input  logic [RW-1:0]     rnd_i,
  input  logic [OUT_W-1:0]  mask_i,
  output logic              vld_o,
  output logic [OUT_W-1:0]  data_o,
  output logic              ovf_o
);

  localparam logic [RW-1:0]    U_MAX = RW'((2 ** OUT_W) - 1);
  localparam logic [RW-1:0]    S_MAX = RW'((2 ** (OUT_W - 1)) - 1);
  localparam logic [RW-1:0]    S_MIN = RW'(-(2 ** (OUT_W - 1)));
  localparam logic [OUT_W-1:0] U_LIM = '1;
  localparam logic [OUT_W-1:0] S_HI  = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_LO  = {1'b1, {(OUT_W-1){1'b0}}};

  logic             pos_ovf;
  logic             neg_ovf;
  logic [OUT_W-1:0] sel;
  logic [OUT_W-1:0] data_d;

  always_comb begin
    if (sgn_i) begin
      pos_ovf = $signed(rnd_i) > $signed(S_MAX);
      neg_ovf = $signed(rnd_i) < $signed(S_MIN);
    end else begin
      pos_ovf = rnd_i > U_MAX;
      neg_ovf = 1'b0;
    end
    if (pos_ovf)      sel = sgn_i ? S_HI : U_LIM;
    else if (neg_ovf) sel = S_LO;
    else              sel = rnd_i[OUT_W-1:0];
    // limits are masked too, so low bits stay clear
    data_d = sel & mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        data_o <= data_d;
        ovf_o  <= pos_ovf | neg_ovf;
      end
    end
  end

endmodule

// File: rtl/mix_out_rounder.sv
module mix_out_rounder
  import mix_round_pkg::*;
#(
  parameter int OUT_W  = 13,
  parameter int HEAD_W = 1,
  parameter int K0     = 8,
  parameter int K1     = 10,
  parameter int K2     = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [OUT_W+HEAD_W-1:0]  sum_i,
  input  logic [1:0]               prec_i,
  input  logic                     signed_i,
  input  logic                     oe_ni,
  output logic                     valid_o,
  output logic [OUT_W-1:0]         data_o,
  output logic                     ovf_o,
  output logic                     drive_o
);

  localparam int RW = OUT_W + HEAD_W + 1;

  logic [OUT_W-1:0] bias;
  logic [OUT_W-1:0] mask;
  logic             s1_vld;
  logic             s1_sgn;
  logic [RW-1:0]    s1_rnd;
  logic [OUT_W-1:0] s1_mask;
  logic             vld_q;
  logic [OUT_W-1:0] data_q;
  logic             ovf_q;

  mix_round_mask #(
    .OUT_W (OUT_W),
    .K0    (K0),
    .K1    (K1),
    .K2    (K2)
  ) u_mask (
    .prec_i (prec_e'(prec_i)),
    .bias_o (bias),
    .mask_o (mask)
  );

  mix_round_add #(
    .OUT_W  (OUT_W),
    .HEAD_W (HEAD_W)
  ) u_add (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sum_i   (sum_i),
    .sgn_i   (signed_i),
    .bias_i  (bias),
    .mask_i  (mask),
    .vld_o   (s1_vld),
    .sgn_o   (s1_sgn),
    .rnd_o   (s1_rnd),
    .mask_o  (s1_mask)
  );

  mix_round_sat #(
    .OUT_W  (OUT_W),
    .HEAD_W (HEAD_W)
  ) u_sat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .sgn_i  (s1_sgn),
    .rnd_i  (s1_rnd),
    .mask_i (s1_mask),
    .vld_o  (vld_q),
    .data_o (data_q),
    .ovf_o  (ovf_q)
  );

  assign valid_o = vld_q;
  assign ovf_o   = ovf_q;
  assign drive_o = ~oe_ni;
  assign data_o  = oe_ni ? '0 : data_q;

endmodule

// File: rtl/mix_out_rounder_chk.sv
module mix_out_rounder_chk #(
  parameter int OUT_W  = 13,
  parameter int HEAD_W = 1,
  parameter int K0     = 8,
  localparam int RW    = OUT_W + HEAD_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        prec_i,
  input logic              oe_ni,
  input logic              valid_o,
  input logic [OUT_W-1:0]  data_o,
  input logic              drive_o,
  input logic              s1_vld,
  input logic              s1_sgn,
  input logic [RW-1:0]     s1_rnd,
  input logic [OUT_W-1:0]  data_q,
  input logic              ovf_q
);

  localparam logic [OUT_W-1:0] LOW0  = OUT_W'((2 ** (OUT_W - K0)) - 1);
  localparam logic [RW-1:0]    U_MAX = RW'((2 ** OUT_W) - 1);
  localparam logic [RW-1:0]    S_MIN = RW'(-(2 ** (OUT_W - 1)));
  localparam logic [OUT_W-1:0] S_LO  = {1'b1, {(OUT_W-1){1'b0}}};

  // R1
  coarse_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == 2'd0) |=> ##1 ((data_q & LOW0) == '0));

  // R4
  unsigned_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && !s1_sgn && s1_rnd > U_MAX) |=> (ovf_q && (&data_q[OUT_W-1 -: K0])));

  // R5
  signed_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_sgn && $signed(s1_rnd) < $signed(S_MIN)) |=> (ovf_q && data_q == S_LO));

  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);

  // R7
  invalid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);

  // R8
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld |=> ($stable(data_q) && $stable(ovf_q)));

  // R9
  bus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (data_o == '0 && !drive_o));

endmodule

bind mix_out_rounder mix_out_rounder_chk #(
  .OUT_W  (OUT_W),
  .HEAD_W (HEAD_W),
  .K0     (K0)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .prec_i  (prec_i),
  .oe_ni   (oe_ni),
  .valid_o (valid_o),
  .data_o  (data_o),
  .drive_o (drive_o),
  .s1_vld  (s1_vld),
  .s1_sgn  (s1_sgn),
  .s1_rnd  (s1_rnd),
  .data_q  (data_q),
  .ovf_q   (ovf_q)
);

// File: tb/tb_mix_out_rounder.sv
module tb_mix_out_rounder;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [13:0] sum_i = '0;
  logic [1:0]  prec_i = '0;
  logic        signed_i = 1'b0;
  logic        oe_ni = 1'b0;
  logic        valid_o;
  logic [12:0] data_o;
  logic        ovf_o;
  logic        drive_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    pv [2];
  int    pd [2];
  bit    po [2];
  string pt [2];
  int    cur_d = 0;
  bit    cur_o = 0;

  always #10 clk_i = ~clk_i;

  mix_out_rounder dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sum_i    (sum_i),
    .prec_i   (prec_i),
    .signed_i (signed_i),
    .oe_ni    (oe_ni),
    .valid_o  (valid_o),
    .data_o   (data_o),
    .ovf_o    (ovf_o),
    .drive_o  (drive_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(int s, int p, bit g, output int d, output bit o);
    int x, drop, r, hi, lo, m;
    x    = (g && s >= 8192) ? s - 16384 : s;
    drop = (p == 0) ? 5 : (p == 1) ? 3 : (p == 2) ? 1 : 0;
    r    = x + ((drop > 0) ? (1 << (drop - 1)) : 0);
    m    = ~((1 << drop) - 1);
    hi   = g ? 4095 : 8191;
    lo   = g ? -4096 : 0;
    if (r > hi) begin o = 1; r = hi; end
    else if (r < lo) begin o = 1; r = lo; end
    else o = 0;
    d = (r & m) & 32'h1FFF;
  endfunction

  task automatic step(bit v, int s, int p, bit g, string tag);
    int d;
    bit o;
    @(negedge clk_i);
    if (pv[0]) begin
      cur_d = pd[0];
      cur_o = po[0];
    end
    chk(valid_o == pv[0], pt[0], "valid_o", valid_o, pv[0]);
    chk(data_o == cur_d[12:0], pt[0], "data_o", data_o, cur_d);
    chk(ovf_o == cur_o, pt[0], "ovf_o", ovf_o, cur_o);
    pv[0] = pv[1]; pd[0] = pd[1]; po[0] = po[1]; pt[0] = pt[1];
    model(s, p, g, d, o);
    pv[1] = v; pd[1] = d; po[1] = o; pt[1] = tag;
    valid_i  = v;
    sum_i    = s[13:0];
    prec_i   = p[1:0];
    signed_i = g;
  endtask

  task automatic oe_probe();
    #2 oe_ni = 1'b1;
    #1;
    chk(data_o == '0, "R9", "data_o off", data_o, 0);
    chk(drive_o == 1'b0, "R9", "drive_o off", drive_o, 0);
    oe_ni = 1'b0;
    #1;
    chk(data_o == cur_d[12:0], "R9", "data_o on", data_o, cur_d);
    chk(drive_o == 1'b1, "R9", "drive_o on", drive_o, 1);
  endtask

  initial begin
    int lfsr;
    for (int i = 0; i < 2; i++) begin
      pv[i] = 0; pd[i] = 0; po[i] = 0; pt[i] = "R10";
    end
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && data_o == '0 && ovf_o == 1'b0, "R10", "reset outputs",
        {valid_o, data_o, ovf_o}, 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R10");

    // R1: each precision on the same value
    step(1, 16'h0ABC, 0, 0, "R1");
    step(1, 16'h0ABC, 1, 0, "R1");
    step(1, 16'h0ABC, 2, 0, "R1");
    step(1, 16'h0ABC, 3, 0, "R1");
    step(1, 16'h1557, 0, 1, "R1");
    // R2: ties and just-below-ties
    step(1, 4, 1, 0, "R2");
    step(1, 3, 1, 0, "R2");
    step(1, 16, 0, 0, "R2");
    step(1, 15, 0, 0, "R2");
    step(1, 14'h3FFF, 0, 1, "R2");
    step(1, 14'h3FF0, 0, 1, "R2");
    // R4: unsigned overflow, incl. carry into overflow
    step(1, 16'h1FF0, 0, 0, "R4");
    step(1, 16'h3000, 3, 0, "R4");
    step(1, 16'h1FFF, 2, 0, "R4");
    step(1, 16'h1FFF, 3, 0, "R6");
    step(1, 16'h1FEF, 0, 0, "R6");
    // R5: signed limits
    step(1, 16'h0FFF, 2, 1, "R5");
    step(1, 16'h0FF0, 0, 1, "R5");
    step(1, 16'h2000, 1, 1, "R5");
    step(1, 16'h2FFF, 3, 1, "R5");
    step(1, 16'h3000, 3, 1, "R6");
    step(1, 16'h0FFF, 3, 1, "R6");
    oe_probe();
    // R8: gaps with junk must not change the result
    step(0, 16'h3FFF, 3, 0, "R8");
    step(0, 16'h1234, 0, 1, "R8");
    step(0, 16'h2000, 2, 1, "R8");
    oe_probe();
    // R3: controls switched on back-to-back pixels
    step(1, 16'h1FF8, 0, 0, "R3");
    step(1, 16'h1FF8, 3, 1, "R3");
    step(1, 16'h1FF8, 1, 0, "R3");
    step(0, 16'h0000, 2, 1, "R3");
    step(1, 16'h1FF8, 2, 1, "R3");
    step(1, 16'h0003, 1, 0, "R7");
    step(0, 16'h0000, 0, 0, "R7");
    step(1, 16'h0155, 3, 0, "R7");
    oe_probe();

    lfsr = 32'h1ACE5EED;
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >>> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(((lfsr >> 17) & 3) != 0, lfsr & 16383, (lfsr >> 14) & 3, (lfsr >> 16) & 1, "R3");
    end
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule